// File: doc/BRIEF.md
# Drift-Syntonized Delta Tick Generator

This block produces the delta strobe that paces a time-aware schedule engine. It runs on the free-running scheduler clock, one tick per clock cycle, and emits a one-cycle pulse at the end of every delta. A delta is nominally 25 ticks, which is 200 ns.

The scheduler clock runs alongside a time-of-day counter that a servo elsewhere rate-corrects. That counter arrives on `tod_i` in nominal tick units. The generator divides time into correction periods. A period ends on the first cycle where the time-of-day elapsed since the period began reaches `corr_period_i`, so the period is measured in the corrected time domain.

At each period boundary the generator works out how far the two time bases drifted, counted in ticks, and adds this to a pending correction. From that boundary onward, each new delta absorbs at most 5 ticks of the pending amount. Anything beyond that is carried over to later deltas. As a result, the first deltas of a period can be stretched or shrunk, while the average delta stays at the nominal length.

Top module: `delta_syntonizer`

## Requirements
- R1: After reset, and until the first `start_i` pulse, `delta_o` stays low.
- R2: A `start_i` pulse sampled at a clock edge (re)starts the generator. With no drift, `delta_o` then pulses for one cycle every 25 cycles, and the first pulse is visible 25 cycles after the start edge.
- R3: A correction period ends at the first clock edge where `tod_i` minus the time-of-day captured at the start of the period is at least `corr_period_i`. At that edge the drift is the elapsed time-of-day minus the number of clock edges since the period began, and that edge's `tod_i` becomes the start of the next period.
- R4: The pending correction changes only at period boundaries, by adding the drift, and at delta starts, by removing the amount applied. A delta that starts on the same edge as a boundary already uses the updated amount.
- R5: Each new delta length is the nominal 25 minus the pending correction clamped to ±5, so every delta after the first lasts between 20 and 30 cycles and `delta_o` is never high on two consecutive cycles.
- R6: Pending correction beyond the ±5 per-delta limit is kept and applied in later deltas, never dropped.
- R7: When the time-of-day runs ahead of the tick count, the drift is positive and deltas are shortened. When it runs behind, deltas are lengthened.
- R8: A `start_i` pulse while running clears the pending correction, restarts the period at the current `tod_i` and restarts the delta at the nominal length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Scheduler tick clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start or restart pulse |
| tod_i | input | TOD_W | Rate-corrected time-of-day, in nominal tick units |
| corr_period_i | input | TOD_W | Correction period length, in time-of-day units |
| delta_o | output | 1 | One-cycle strobe at the end of each delta |

## Verification
The bench keeps the default nominal length of 25 and limit of 5. It drives the time-of-day with per-cycle steps of 0, 1 or 2, which creates positive and negative drift of any size. Correction periods of 100 to 300 units keep boundaries frequent, so that within a few thousand cycles the clamp saturates in both directions and the carry-over has to drain across many deltas. A boundary also lands on the same edge as a delta start. A forced 150-tick surge checks that a large backlog is spread over many deltas at the 5-tick limit.

// File: rtl/delta_syntonizer.sv
module delta_syntonizer #(
  parameter int NOM_TICKS = 25,
  parameter int MAX_ADJ   = 5,
  parameter int TOD_W     = 32,
  parameter int PEND_W    = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [TOD_W-1:0] tod_i,
  input  logic [TOD_W-1:0] corr_period_i,
  output logic             delta_o
);
  localparam int CNT_W = $clog2(NOM_TICKS + MAX_ADJ + 1);
  localparam logic signed [PEND_W-1:0] LIM = PEND_W'(MAX_ADJ);
  localparam logic signed [PEND_W-1:0] NOM_M1 = PEND_W'(NOM_TICKS - 1);

  logic                     running;
  logic [TOD_W-1:0]         per_start, eng_cnt;
  logic signed [PEND_W-1:0] pend;
  logic [CNT_W-1:0]         cnt;

  wire [TOD_W-1:0] elapsed = tod_i - per_start;
  wire boundary = running && (elapsed >= corr_period_i);
  wire signed [PEND_W-1:0] drift = PEND_W'(elapsed) - PEND_W'(eng_cnt) - PEND_W'(1);
  wire signed [PEND_W-1:0] pend_eff = boundary ? pend + drift : pend;
  wire signed [PEND_W-1:0] adj = (pend_eff > LIM) ? LIM : ((pend_eff < -LIM) ? -LIM : pend_eff);
  wire signed [PEND_W-1:0] len_m1 = NOM_M1 - adj;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      running   <= 1'b0;
      per_start <= '0;
      eng_cnt   <= '0;
      pend      <= '0;
      cnt       <= '0;
      delta_o   <= 1'b0;
    end else if (start_i) begin
      running   <= 1'b1;
      per_start <= tod_i;
      eng_cnt   <= '0;
      pend      <= '0;
      cnt       <= CNT_W'(NOM_TICKS - 1);
      delta_o   <= 1'b0;
    end else if (running) begin
      if (boundary) begin
        per_start <= tod_i;
        eng_cnt   <= '0;
      end else begin
        eng_cnt   <= eng_cnt + 1'b1;
      end
      if (cnt == '0) begin
        cnt     <= len_m1[CNT_W-1:0];
        pend    <= pend_eff - adj;
        delta_o <= 1'b1;
      end else begin
        cnt     <= cnt - 1'b1;
        pend    <= pend_eff;
        delta_o <= 1'b0;
      end
    end
  end
endmodule

module delta_syntonizer_chk #(
  parameter int NOM_TICKS = 25,
  parameter int MAX_ADJ   = 5
) (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic delta_o
);
  logic       seen_start, seen_strobe;
  logic [7:0] gap;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      seen_start  <= 1'b0;
      seen_strobe <= 1'b0;
      gap         <= '0;
    end else if (start_i) begin
      seen_start  <= 1'b1;
      seen_strobe <= 1'b0;
      gap         <= '0;
    end else if (delta_o) begin
      seen_strobe <= 1'b1;
      gap         <= 8'd1;
    end else if (gap != 8'hff) begin
      gap         <= gap + 1'b1;
    end
  end

  a_r1_idle_before_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_start |-> !delta_o);
  a_r2_quiet_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !delta_o);
  a_r5_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    delta_o |=> !delta_o);
  a_r5_len_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (delta_o && seen_strobe && !start_i) |->
      (gap >= 8'(NOM_TICKS - MAX_ADJ) && gap <= 8'(NOM_TICKS + MAX_ADJ)));
endmodule

bind delta_syntonizer delta_syntonizer_chk #(.NOM_TICKS(NOM_TICKS), .MAX_ADJ(MAX_ADJ)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .delta_o(delta_o));

// File: tb/test_delta_syntonizer.sv
module test_delta_syntonizer;
  localparam int NOM = 25;
  localparam int LIM = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] tod = 32'd1000;
  logic [31:0] period = 32'd100;
  logic        delta;

  int checks = 0, errors = 0;
  string tag = "R1";

  delta_syntonizer i_delta_syntonizer (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .tod_i(tod),
    .corr_period_i(period), .delta_o(delta));

  always #10 clk = ~clk;

  // Reference model derived from the requirements
  bit          m_run = 0, m_strb = 0;
  int          m_cnt = 0, m_pend = 0, m_eng = 0;
  logic [31:0] m_ps = 0;

  function automatic int clamp_adj(int v);
    if (v > LIM) return LIM;
    if (v < -LIM) return -LIM;
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_strb = 0; m_cnt = 0; m_pend = 0; m_eng = 0; m_ps = 0;
    end else if (start) begin
      m_run = 1; m_ps = tod; m_eng = 0; m_pend = 0; m_cnt = NOM - 1; m_strb = 0;
    end else if (m_run) begin
      int el, pe, a;
      el = int'(tod - m_ps);
      pe = m_pend;
      if (el >= int'(period)) begin
        pe = pe + (el - (m_eng + 1));
        m_ps = tod; m_eng = 0;
      end else m_eng++;
      if (m_cnt == 0) begin
        a = clamp_adj(pe);
        m_cnt = NOM - a - 1; pe = pe - a; m_strb = 1;
      end else begin
        m_cnt--; m_strb = 0;
      end
      m_pend = pe;
    end
  end

  always @(negedge clk) begin
    checks++;
    if (delta !== m_strb) begin
      errors++;
      $display("FAIL %s: delta_o=%b expected %b at %0t", tag, delta, m_strb, $time);
    end
  end

  // Observed strobe spacing for the directed carry-over case
  int last_strobe = -1, cyc = 0;
  int gaps[$];
  always @(negedge clk) begin
    cyc++;
    if (delta) begin
      if (last_strobe >= 0) gaps.push_back(cyc - last_strobe);
      last_strobe = cyc;
    end
  end

  task automatic step_cycles(int n, int mode);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      case (mode)
        0: tod = tod + 1;
        1: tod = tod + 2;
        2: tod = tod + (($urandom % 4 == 0) ? 0 : 1);
        default: tod = tod + ($urandom % 3);
      endcase
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1; tod = tod + 1;
    @(negedge clk); start = 1'b0; tod = tod + 1;
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tag = "R1"; step_cycles(60, 0);
    tag = "R2"; pulse_start(); step_cycles(400, 0);
    tag = "R7"; step_cycles(30, 1); step_cycles(300, 0);
    tag = "R7"; step_cycles(400, 2);
    // R6: force a large backlog, then expect many deltas at the 5-tick limit
    tag = "R6"; period = 32'd200; step_cycles(150, 1);
    gaps.delete(); step_cycles(700, 0);
    begin
      int short_cnt = 0;
      foreach (gaps[i]) if (gaps[i] == NOM - LIM) short_cnt++;
      checks++;
      if (short_cnt < 10) begin
        errors++;
        $display("FAIL R6: clamped deltas=%0d expected >= 10", short_cnt);
      end
    end
    tag = "R3"; for (int p = 0; p < 8; p++) begin
      period = 32'd100 + ($urandom % 200); step_cycles(500, 3);
    end
    tag = "R4"; period = 32'd125; step_cycles(1000, 3);
    tag = "R8"; step_cycles(40, 1); pulse_start(); step_cycles(300, 0);
    tag = "R5"; step_cycles(3000, 3);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule